// File: doc/BRIEF.md
# Paged indirect register access bridge

This block sits behind the register side of a management port, for example the register file of a serial management slave. It gives a host a handful of 16-bit registers through which it can reach a much larger internal register space. That space is organised in 256 pages of 256 offsets, and it holds registers of 8, 16, 32, 48 or 64 bits. The host selects a page and fills a four-word data window. It then writes an offset together with a read or a write command. The bridge runs one access on a simple internal request/acknowledge bus.

The command bits double as busy flags. They read back as one while the access is outstanding and clear once it has finished, so the host polls them. For a read, the result lands in the data window. For a write, the data sent on the bus is a snapshot of the window taken when the command was accepted. If the internal bus never acknowledges, the access is abandoned after a parameterised number of cycles, so the host can never hang.

The sequencer has three states:
- `ST_IDLE` waits for a command.
- `ST_RD` holds a read request.
- `ST_WR` holds a write request.

The transitions are:
- `go_read` (ST_IDLE to ST_RD) and `go_write` (ST_IDLE to ST_WR) fire on an accepted command.
- `acked` (ST_RD or ST_WR to ST_IDLE) fires when the bus acknowledges.
- `expired` (ST_RD or ST_WR to ST_IDLE) fires when the timeout is reached without an acknowledge.

Top module: `paged_reg_bridge`

## Requirements
- R1: After reset, every mapped management register reads zero and no internal request is raised.
- R2: Address 0x10 is the page register. Bits 15:8 hold the page and bit 0 holds the page-enable flag. All other bits read zero.
- R3: Addresses 0x18 to 0x1B form the data window, with 0x18 the least significant word. The host can write and read back each word.
- R4: Address 0x11 is the command register. Bits 15:8 hold the offset, bit 0 requests a write and bit 1 requests a read. A command written while idle with exactly one of these bits set starts an access, and that bit reads back as one while the access is busy.
- R5: A write access presents the latched page, the offset, write enable high, and 64-bit data equal to the window (0x18 in bits 15:0, up to 0x1B in bits 63:48).
- R6: The write data is captured when the command is accepted. Host writes to the window during the access do not change it.
- R7: When a read access is acknowledged, the window is loaded with the read data, bits 15:0 into 0x18. An 8-bit result therefore sits in the low byte of 0x18.
- R8: The command bits read zero from the first cycle after the clock edge at which the acknowledge is sampled. With an acknowledge after d idle bus cycles, the host sees busy for d+1 cycles.
- R9: A command with both bits 1:0 set starts no access and reads back with both bits zero. Its offset is still stored.
- R10: A write to 0x11 while an access is busy is ignored: no new access is started and the offset is unchanged.
- R11: If no acknowledge arrives within TIMEOUT_CYC request cycles, the request is dropped and the command bits clear. A read abandoned this way leaves the window unchanged.
- R12: Unmapped addresses read zero, and writes to them have no effect.
- R13: While a request is outstanding, its page, offset, direction and data are held stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mg_we | input | 1 | Management register write strobe |
| mg_addr | input | 5 | Management register address |
| mg_wdata | input | 16 | Management write data |
| mg_rdata | output | 16 | Management read data (combinational on mg_addr) |
| ib_req | output | 1 | Internal bus request |
| ib_we | output | 1 | Internal bus write enable |
| ib_page | output | 8 | Internal bus page |
| ib_offs | output | 8 | Internal bus register offset |
| ib_wdata | output | 64 | Internal bus write data |
| ib_rdata | input | 64 | Internal bus read data |
| ib_ack | input | 1 | Internal bus acknowledge |

## Verification
The bench builds the bridge with TIMEOUT_CYC set to 8 and the other parameters at their defaults. The short timeout lets a silent internal bus be abandoned within a few host polls, so the exact busy length of R11 is checked directly. A bench responder acknowledges after a random delay of zero to three cycles, which makes the busy length of R8 checkable for every access. The same responder can also stay silent.

// File: rtl/pr_pkg.sv
`timescale 1ns/1ps
package pr_pkg;
    localparam int MG_AW      = 5;
    localparam int A_PAGE     = 'h10;
    localparam int A_CMD      = 'h11;
    localparam int A_DATA0    = 'h18;
    localparam int CMD_WR_BIT = 0;
    localparam int CMD_RD_BIT = 1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2
    } pr_state_e;
endpackage

// File: rtl/pr_window.sv
`timescale 1ns/1ps
module pr_window #(
    parameter int DW    = 16,
    parameter int WORDS = 4,
    localparam int BW   = DW * WORDS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WORDS-1:0] host_we,
    input  logic [DW-1:0]    host_wdata,
    input  logic             load_en,
    input  logic [BW-1:0]    load_data,
    output logic [BW-1:0]    win_q
);
    // one register per window word; a bus read result wins over a host write
    for (genvar gi = 0; gi < WORDS; gi++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                win_q[gi*DW +: DW] <= '0;
            end else if (load_en) begin
                win_q[gi*DW +: DW] <= load_data[gi*DW +: DW];
            end else if (host_we[gi]) begin
                win_q[gi*DW +: DW] <= host_wdata;
            end
        end
    end

    // R7: a read result appears in the window one edge after load
    a_r7_load: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (win_q == $past(load_data)));
endmodule

// File: rtl/pr_ctrl.sv
`timescale 1ns/1ps
module pr_ctrl
    import pr_pkg::*;
#(
    parameter int DW          = 16,
    parameter int PW          = 8,
    parameter int OW          = 8,
    parameter int BW          = 64,
    parameter int TIMEOUT_CYC = 16,
    localparam int CW         = $clog2(TIMEOUT_CYC + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_we,
    input  logic [DW-1:0] cmd_wdata,
    input  logic [PW-1:0] page_q,
    input  logic [BW-1:0] win_q,
    input  logic          ib_ack,
    output logic          ib_req,
    output logic          ib_we,
    output logic [PW-1:0] ib_page,
    output logic [OW-1:0] ib_offs,
    output logic [BW-1:0] ib_wdata,
    output logic [OW-1:0] offs_q,
    output logic          busy_rd,
    output logic          busy_wr,
    output logic          rd_load
);
    pr_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic [PW-1:0] page_s;
    logic [BW-1:0] wdata_s;
    logic          accept, go_read, go_write, expired;

    assign accept   = cmd_we && (state_q == ST_IDLE);
    assign go_read  = accept && cmd_wdata[CMD_RD_BIT] && !cmd_wdata[CMD_WR_BIT];
    assign go_write = accept && cmd_wdata[CMD_WR_BIT] && !cmd_wdata[CMD_RD_BIT];
    assign expired  = (cnt_q == CW'(TIMEOUT_CYC - 1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (go_read)       state_d = ST_RD;
                else if (go_write) state_d = ST_WR;
            end
            ST_RD, ST_WR: begin
                if (ib_ack || expired) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register, timer and snapshot of the request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            page_s  <= '0;
            wdata_s <= '0;
            offs_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE) cnt_q <= '0;
            else                    cnt_q <= cnt_q + 1'b1;
            if (accept) begin
                offs_q  <= cmd_wdata[DW-1 -: OW];
                page_s  <= page_q;
                wdata_s <= win_q;
            end
        end
    end

    // outputs decoded from the state
    always_comb begin
        ib_req  = 1'b0;
        ib_we   = 1'b0;
        busy_rd = 1'b0;
        busy_wr = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RD: begin ib_req = 1'b1; busy_rd = 1'b1; end
            ST_WR: begin ib_req = 1'b1; ib_we = 1'b1; busy_wr = 1'b1; end
            default: ;
        endcase
        rd_load  = busy_rd && ib_ack;
        ib_page  = page_s;
        ib_offs  = offs_q;
        ib_wdata = wdata_s;
    end

    a_r13_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ib_req && !ib_ack && !expired) |=> (ib_req && $stable(ib_we) &&
            $stable(ib_page) && $stable(ib_offs) && $stable(ib_wdata)));
    a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ib_req && ib_ack) |=> (!busy_rd && !busy_wr));
    a_r9_both_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && !ib_req && (cmd_wdata[1:0] == 2'b11)) |=> !ib_req);
    a_r10_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (ib_req && cmd_we) |=> $stable(offs_q));
    a_r4_one_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({busy_rd, busy_wr}));
endmodule

// File: rtl/paged_reg_bridge.sv
`timescale 1ns/1ps
module paged_reg_bridge
    import pr_pkg::*;
#(
    parameter int DW          = 16,
    parameter int WORDS       = 4,
    parameter int PW          = 8,
    parameter int OW          = 8,
    parameter int TIMEOUT_CYC = 16,
    localparam int BW         = DW * WORDS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mg_we,
    input  logic [MG_AW-1:0] mg_addr,
    input  logic [DW-1:0]    mg_wdata,
    output logic [DW-1:0]    mg_rdata,
    output logic             ib_req,
    output logic             ib_we,
    output logic [PW-1:0]    ib_page,
    output logic [OW-1:0]    ib_offs,
    output logic [BW-1:0]    ib_wdata,
    input  logic [BW-1:0]    ib_rdata,
    input  logic             ib_ack
);
    logic [PW-1:0]    page_q;
    logic             pen_q;
    logic [OW-1:0]    offs_q;
    logic             busy_rd, busy_wr, rd_load, cmd_we;
    logic [WORDS-1:0] win_we;
    logic [BW-1:0]    win_q;

    assign cmd_we = mg_we && (mg_addr == MG_AW'(A_CMD));
    for (genvar gi = 0; gi < WORDS; gi++) begin : g_dec
        assign win_we[gi] = mg_we && (mg_addr == MG_AW'(A_DATA0 + gi));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= '0;
            pen_q  <= 1'b0;
        end else if (mg_we && (mg_addr == MG_AW'(A_PAGE))) begin
            page_q <= mg_wdata[DW-1 -: PW];
            pen_q  <= mg_wdata[0];
        end
    end

    always_comb begin
        mg_rdata = '0;
        if (mg_addr == MG_AW'(A_PAGE))
            mg_rdata = {page_q, {(DW-PW-1){1'b0}}, pen_q};
        else if (mg_addr == MG_AW'(A_CMD))
            mg_rdata = {offs_q, {(DW-OW-2){1'b0}}, busy_rd, busy_wr};
        for (int i = 0; i < WORDS; i++)
            if (mg_addr == MG_AW'(A_DATA0 + i)) mg_rdata = win_q[i*DW +: DW];
    end

    pr_window #(.DW(DW), .WORDS(WORDS)) u_window (
        .clk(clk), .rst_n(rst_n), .host_we(win_we), .host_wdata(mg_wdata),
        .load_en(rd_load), .load_data(ib_rdata), .win_q(win_q));

    pr_ctrl #(.DW(DW), .PW(PW), .OW(OW), .BW(BW), .TIMEOUT_CYC(TIMEOUT_CYC)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(mg_wdata),
        .page_q(page_q), .win_q(win_q), .ib_ack(ib_ack), .ib_req(ib_req),
        .ib_we(ib_we), .ib_page(ib_page), .ib_offs(ib_offs), .ib_wdata(ib_wdata),
        .offs_q(offs_q), .busy_rd(busy_rd), .busy_wr(busy_wr), .rd_load(rd_load));

    // R11: independent run-length counter bounds every request
    logic [$clog2(TIMEOUT_CYC+1)-1:0] run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      run_q <= '0;
        else if (ib_req) run_q <= run_q + 1'b1;
        else             run_q <= '0;
    end
    a_r11_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        ib_req |-> (run_q < ($clog2(TIMEOUT_CYC+1))'(TIMEOUT_CYC)));
endmodule

// File: tb/test_paged_reg_bridge.sv
`timescale 1ns/1ps
module test_paged_reg_bridge;
    localparam int TMO = 8;
    logic        clk = 0, rst_n = 0, mg_we = 0;
    logic [4:0]  mg_addr = '0;
    logic [15:0] mg_wdata = '0, mg_rdata;
    logic        ib_req, ib_we, ib_ack = 0;
    logic [7:0]  ib_page, ib_offs;
    logic [63:0] ib_wdata, ib_rdata;

    int errors = 0, checks = 0, nreq = 0, dly = 0, scnt = 0;
    bit no_ack = 0, req_prev = 0, done = 0;
    logic [7:0]  cap_page, cap_offs;
    logic        cap_we;
    logic [63:0] cap_wdata;

    always #2.5 clk = ~clk;  // 200 MHz

    paged_reg_bridge #(.TIMEOUT_CYC(TMO)) i_paged_reg_bridge (
        .clk(clk), .rst_n(rst_n), .mg_we(mg_we), .mg_addr(mg_addr),
        .mg_wdata(mg_wdata), .mg_rdata(mg_rdata), .ib_req(ib_req), .ib_we(ib_we),
        .ib_page(ib_page), .ib_offs(ib_offs), .ib_wdata(ib_wdata),
        .ib_rdata(ib_rdata), .ib_ack(ib_ack));

    function automatic logic [63:0] rd_pat(input logic [7:0] p, input logic [7:0] o);
        return {p, o, p ^ o, ~o, o + 8'd3, p, 8'hC3 ^ o, o};
    endfunction
    assign ib_rdata = rd_pat(ib_page, ib_offs);

    // internal-bus responder: acknowledge after dly idle cycles
    always @(negedge clk) begin
        if (ib_req && !req_prev) nreq <= nreq + 1;
        req_prev <= ib_req;
        if (ib_ack) begin
            ib_ack <= 0; scnt <= 0;
        end else if (ib_req && !no_ack) begin
            if (scnt >= dly) begin
                ib_ack <= 1; cap_page <= ib_page; cap_offs <= ib_offs;
                cap_we <= ib_we; cap_wdata <= ib_wdata;
            end else scnt <= scnt + 1;
        end else scnt <= 0;
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic mwr(input logic [4:0] a, input logic [15:0] d);
        mg_addr = a; mg_wdata = d; mg_we = 1;
        @(negedge clk);
        mg_we = 0;
    endtask

    task automatic mrd(input logic [4:0] a, output logic [15:0] d);
        mg_addr = a; #1; d = mg_rdata;
        @(negedge clk);
    endtask

    task automatic wait_idle(output int cyc);
        logic [15:0] v;
        cyc = 0;
        do begin mrd(5'h11, v); cyc++; end while (v[1:0] != 0 && cyc < 50);
    endtask

    task automatic load_win(input logic [63:0] d);
        for (int i = 0; i < 4; i++) mwr(5'(5'h18 + i), d[i*16 +: 16]);
    endtask

    task automatic read_win(output logic [63:0] d);
        logic [15:0] v;
        for (int i = 0; i < 4; i++) begin mrd(5'(5'h18 + i), v); d[i*16 +: 16] = v; end
    endtask

    initial begin
        #(5.0 * 150000);
        errors++; checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [63:0] w, wexp;
        int cyc, n0;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset values
        mrd(5'h10, v); chk("R1 page", v, 0);
        mrd(5'h11, v); chk("R1 cmd", v, 0);
        read_win(w);   chk("R1 window", w, 0);
        chk("R1 req", ib_req, 0);
        // R2: page register keeps only page and enable
        mwr(5'h10, 16'hABCD); mrd(5'h10, v); chk("R2 page", v, 16'hAB01);
        // R3: window readback
        load_win(64'h1122_3344_5566_7788); read_win(w);
        chk("R3 window", w, 64'h1122_3344_5566_7788);
        // R12: unmapped write/read
        mwr(5'h12, 16'hFFFF); mrd(5'h12, v); chk("R12 unmapped", v, 0);
        read_win(w); chk("R12 window intact", w, 64'h1122_3344_5566_7788);
        // R4/R5/R6: directed write, window modified during busy
        dly = 3;
        mwr(5'h11, 16'h4201);
        mrd(5'h11, v); chk("R4 busy write bit", v, 16'h4201);
        mwr(5'h18, 16'hDEAD);
        wait_idle(cyc);
        chk("R5 page", cap_page, 8'hAB); chk("R5 offs", cap_offs, 8'h42);
        chk("R5 we", cap_we, 1);
        chk("R6 snapshot", cap_wdata, 64'h1122_3344_5566_7788);
        // R7/R8: directed read, 8-bit result in low byte of 0x18
        dly = 0;
        mwr(5'h10, 16'h0701); mwr(5'h11, 16'h9902);
        wait_idle(cyc); chk("R8 busy length", cyc, 2);
        read_win(w); chk("R7 read window", w, rd_pat(8'h07, 8'h99));
        chk("R7 low byte", w[7:0], 8'h99);
        // R9: both bits set
        n0 = nreq;
        mwr(5'h11, 16'h3303); mrd(5'h11, v); chk("R9 bits clear", v, 16'h3300);
        chk("R9 no access", nreq, n0);
        // R10: command write while busy
        dly = 3; n0 = nreq;
        mwr(5'h11, 16'h5502); mwr(5'h11, 16'h6601);
        wait_idle(cyc);
        chk("R10 single access", nreq, n0 + 1);
        chk("R10 offs kept", cap_offs, 8'h55);
        mrd(5'h11, v); chk("R10 readback", v, 16'h5500);
        // R11: no acknowledge
        no_ack = 1; read_win(wexp);
        mwr(5'h11, 16'h7702);
        wait_idle(cyc); chk("R11 abandon time", cyc, TMO + 1);
        read_win(w); chk("R11 window intact", w, wexp);
        no_ack = 0;
        // random mix
        for (int k = 0; k < 40; k++) begin
            logic [7:0] p, o;
            logic [63:0] d;
            p = 8'($urandom); o = 8'($urandom);
            d = {$urandom, $urandom};
            dly = $urandom % 4;
            mwr(5'h10, {p, 8'h01});
            if ($urandom % 2) begin
                load_win(d); mwr(5'h11, {o, 8'h01});
                wait_idle(cyc);
                chk("R5 rnd wdata", cap_wdata, d);
                chk("R5 rnd addr", {cap_page, cap_offs, 7'd0, cap_we}, {p, o, 8'h01});
            end else begin
                mwr(5'h11, {o, 8'h02});
                wait_idle(cyc);
                read_win(w); chk("R7 rnd read", w, rd_pat(p, o));
            end
            chk("R8 rnd busy length", cyc, dly + 2);
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule